// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one short command against a serial NOR flash device, under the control of software. Software sets up the transfer through a word-addressed register port. It writes the opcode, a byte count, which of two chip selects to use, the chip-select timing and, for a program-style command, the bytes to send into a small local buffer. Software then writes an operation word. That word carries independent enable bits for the command phase, data write, data read and status read, plus a start bit.

The engine lowers the chosen chip select and waits the programmed setup time. It shifts the opcode out most significant bit first and then moves the data bytes. Bytes either leave the buffer or are captured into it from the device. The engine then waits the hold time, raises chip select and keeps it high for the programmed deselect time. Only after that does it raise a sticky done flag and clear the start bit. Software polls the done flag or the start bit, reads any received bytes out of the buffer, and clears the flag by writing a one to the clear register.

Top module: `flash_cmd_seq`

## Requirements

- R1: After synchronous reset all chip selects are high, the serial clock and data out are low, the done flag is 0, and the opcode, timing, count and operation registers read as 0.
- R2: The timing register packs hold time in bits 11:8, setup time in bits 7:4 and deselect time in bits 3:0. Chip select goes low on the second clock edge after the start write. It stays low with the serial clock low for setup+1 cycles before the first bit cell.
- R3: Each bit takes two cycles, with the serial clock low and then high, and data out holds the bit through both cycles. Bytes go most significant bit first. Input data is sampled at the end of the low cycle (mode 0).
- R4: Operation register bits are: bit 0 start, bit 1 status read, bit 2 data read, bit 5 data write, bit 7 command. When bit 7 is set, the opcode in bits 7:0 of the opcode register goes out first.
- R5: The byte count is bits 13:0 of the count register, and higher bits are dropped. With data write enabled, count bytes go out from buffer index 0 upward, and data write takes precedence over data read. The buffer is not modified.
- R6: With data read or status read enabled and data write clear, count bytes are captured into the buffer from index 0 upward. Data out stays low during those bytes.
- R7: With command enabled and a count of 0, only the opcode is sent. The chip select then stays low for hold+1 cycles with the clock low, and then stays high for deselect+1 cycles before the operation ends.
- R8: Bit 11 of the chip-select register selects spi_cs_n[0] or spi_cs_n[1]. No more than one chip select is ever low.
- R9: When the deselect time ends, done-flag bit 0 is set and the start bit reads back 0. Writing 1 to bit 0 of the clear register clears the flag.
- R10: While an operation is in progress, writes to every register except the clear register are ignored. This includes a second start.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Word address; bit 6 set selects the data buffer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_cs_n | output | 2 | Active-low chip selects |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| op_done_irq | output | 1 | Sticky done flag (bit 0 of the status register) |

## Verification

The hardest case to reach is a register write that lands while a command is still shifting or waiting out its deselect time. A write like that must leave the opcode, the timing and the operation bits untouched, and it must not start a second command. The stimulus issues these writes, including a fresh start word, in the middle of a program-style command. A reference waveform is built from the requirements and compared on every clock, so it shows directly that no extra chip-select activity follows. The flash model advances its output on each observed serial-clock rise, so a shift or sampling error one bit away from correct shows up as a wrong buffer byte.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_DESEL
    } seq_state_e;

    // field order matches bits 11:8, 7:4, 3:0 of the timing register
    typedef struct packed {
        logic [3:0] hold;
        logic [3:0] setup;
        logic [3:0] desel;
    } cs_timing_t;

    typedef struct packed {
        logic cmd_en;
        logic wr_en;
        logic rd_en;
        logic stat_en;
    } op_ctrl_t;

    localparam logic [3:0] RA_TIMING = 4'd0;
    localparam logic [3:0] RA_OPCODE = 4'd1;
    localparam logic [3:0] RA_COUNT  = 4'd2;
    localparam logic [3:0] RA_CSCFG  = 4'd3;
    localparam logic [3:0] RA_OPCTRL = 4'd4;
    localparam logic [3:0] RA_IRQ    = 4'd5;
    localparam logic [3:0] RA_IRQCLR = 4'd6;

    localparam int OPB_START = 0;
    localparam int OPB_STAT  = 1;
    localparam int OPB_RD    = 2;
    localparam int OPB_WR    = 5;
    localparam int OPB_CMD   = 7;
    localparam int CS_LSB    = 11;

    function automatic logic is_write(op_ctrl_t o);
        return o.wr_en;
    endfunction

    function automatic logic is_read(op_ctrl_t o);
        return !o.wr_en && (o.rd_en || o.stat_en);
    endfunction

    function automatic logic [31:0] op_word(op_ctrl_t o, logic start);
        logic [31:0] w;
        w = '0;
        w[OPB_START] = start;
        w[OPB_STAT]  = o.stat_en;
        w[OPB_RD]    = o.rd_en;
        w[OPB_WR]    = o.wr_en;
        w[OPB_CMD]   = o.cmd_en;
        return w;
    endfunction

endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BUF_DEPTH = 16,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 14,
    parameter int CS_W      = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              done,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_widx,
    input  logic [7:0]        eng_wdata,
    input  logic [IDX_W-1:0]  eng_ridx,
    output logic [7:0]        eng_rdata,
    output cs_timing_t        timing,
    output logic [7:0]        opcode,
    output logic [CNT_W-1:0]  count,
    output logic [CS_W-1:0]   cs_sel,
    output op_ctrl_t          op,
    output logic              start,
    output logic              irq
);

    logic [7:0] buf_mem [BUF_DEPTH];
    logic       buf_sel;
    logic       sw_wr;

    assign buf_sel   = reg_addr[ADDR_W-1];
    assign sw_wr     = reg_wr && !start;
    assign eng_rdata = buf_mem[eng_ridx];

    always_ff @(posedge clk) begin
        if (rst) begin
            timing <= '0;
            opcode <= '0;
            count  <= '0;
            cs_sel <= '0;
            op     <= '0;
            start  <= 1'b0;
            irq    <= 1'b0;
            for (int i = 0; i < BUF_DEPTH; i++) buf_mem[i] <= '0;
        end else begin
            if (sw_wr && buf_sel) begin
                buf_mem[reg_addr[IDX_W-1:0]] <= reg_wdata[7:0];
            end else if (sw_wr) begin
                case (reg_addr)
                    ADDR_W'(RA_TIMING): timing <= reg_wdata[11:0];
                    ADDR_W'(RA_OPCODE): opcode <= reg_wdata[7:0];
                    ADDR_W'(RA_COUNT):  count  <= reg_wdata[CNT_W-1:0];
                    ADDR_W'(RA_CSCFG):  cs_sel <= reg_wdata[CS_LSB +: CS_W];
                    ADDR_W'(RA_OPCTRL): begin
                        op.cmd_en  <= reg_wdata[OPB_CMD];
                        op.wr_en   <= reg_wdata[OPB_WR];
                        op.rd_en   <= reg_wdata[OPB_RD];
                        op.stat_en <= reg_wdata[OPB_STAT];
                        start      <= reg_wdata[OPB_START];
                    end
                    default: ;
                endcase
            end
            if (eng_we) buf_mem[eng_widx] <= eng_wdata;
            if (reg_wr && reg_addr == ADDR_W'(RA_IRQCLR) && reg_wdata[0]) irq <= 1'b0;
            if (done) begin
                irq   <= 1'b1;
                start <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (buf_sel) begin
            reg_rdata[7:0] = buf_mem[reg_addr[IDX_W-1:0]];
        end else begin
            case (reg_addr)
                ADDR_W'(RA_TIMING): reg_rdata[11:0] = timing;
                ADDR_W'(RA_OPCODE): reg_rdata[7:0]  = opcode;
                ADDR_W'(RA_COUNT):  reg_rdata[CNT_W-1:0] = count;
                ADDR_W'(RA_CSCFG):  reg_rdata[CS_LSB +: CS_W] = cs_sel;
                ADDR_W'(RA_OPCTRL): reg_rdata = op_word(op, start);
                ADDR_W'(RA_IRQ):    reg_rdata[0] = irq;
                default: ;
            endcase
        end
    end

    AST_DONE_CLEARS_START: assert property (@(posedge clk) disable iff (rst)
        done |=> !start) else $error("start not cleared");                       // R9
    AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
        done |=> irq) else $error("done flag not set");                          // R9
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (start && $past(start)) |-> ($stable(opcode) && $stable(count) && $stable(timing)))
        else $error("config changed while busy");                                // R10

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
    import flash_seq_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cs_timing_t       timing,
    input  logic [7:0]       opcode,
    input  logic [CNT_W-1:0] count,
    input  op_ctrl_t         op,
    input  logic             miso,
    input  logic [7:0]       buf_rdata,
    output logic [IDX_W-1:0] buf_ridx,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata,
    output logic             done,
    output logic             cs_active,
    output logic             sck,
    output logic             mosi
);

    seq_state_e       state;
    logic [3:0]       cnt;
    logic             phase;
    logic [2:0]       bitn;
    logic             in_cmd;
    logic [CNT_W-1:0] bytes_left;
    logic [IDX_W-1:0] idx;
    logic [7:0]       tx;
    logic [6:0]       rx;
    logic             wr_mode, rd_mode, last_cell, capture;
    logic [7:0]       next_data;

    assign wr_mode   = is_write(op);
    assign rd_mode   = is_read(op);
    assign next_data = wr_mode ? buf_rdata : 8'h00;
    assign last_cell = (state == ST_SHIFT) && !phase && (bitn == 3'd0) && !in_cmd;
    assign capture   = (state == ST_SHIFT) && !phase && !in_cmd && rd_mode;
    assign buf_ridx  = idx;
    assign buf_we    = last_cell && rd_mode;
    assign buf_widx  = idx;
    assign buf_wdata = {rx, miso};
    assign done      = (state == ST_DESEL) && (cnt == 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            phase      <= 1'b0;
            bitn       <= '0;
            in_cmd     <= 1'b0;
            bytes_left <= '0;
            idx        <= '0;
            tx         <= '0;
            rx         <= '0;
            cs_active  <= 1'b0;
            sck        <= 1'b0;
            mosi       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_SETUP;
                    cs_active  <= 1'b1;
                    cnt        <= timing.setup;
                    idx        <= '0;
                    bytes_left <= (wr_mode || rd_mode) ? count : '0;
                end
                ST_SETUP: begin
                    if (cnt != 4'd0) begin
                        cnt <= cnt - 4'd1;
                    end else if (op.cmd_en || bytes_left != '0) begin
                        state  <= ST_SHIFT;
                        in_cmd <= op.cmd_en;
                        tx     <= op.cmd_en ? opcode : next_data;
                        mosi   <= op.cmd_en ? opcode[7] : next_data[7];
                        bitn   <= 3'd7;
                        phase  <= 1'b0;
                    end else begin
                        state <= ST_HOLD;
                        cnt   <= timing.hold;
                    end
                end
                ST_SHIFT: begin
                    if (!phase) begin
                        sck   <= 1'b1;
                        phase <= 1'b1;
                        if (capture) rx <= {rx[5:0], miso};
                        if (last_cell) idx <= idx + 1'b1;
                    end else begin
                        sck   <= 1'b0;
                        phase <= 1'b0;
                        if (bitn != 3'd0) begin
                            bitn <= bitn - 3'd1;
                            mosi <= tx[bitn - 3'd1];
                        end else if (in_cmd ? (bytes_left != '0) : (bytes_left > 1)) begin
                            if (!in_cmd) bytes_left <= bytes_left - 1'b1;
                            in_cmd <= 1'b0;
                            tx     <= next_data;
                            mosi   <= next_data[7];
                            bitn   <= 3'd7;
                        end else begin
                            bytes_left <= '0;
                            in_cmd     <= 1'b0;
                            mosi       <= 1'b0;
                            state      <= ST_HOLD;
                            cnt        <= timing.hold;
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt != 4'd0) begin
                        cnt <= cnt - 4'd1;
                    end else begin
                        cs_active <= 1'b0;
                        state     <= ST_DESEL;
                        cnt       <= timing.desel;
                    end
                end
                ST_DESEL: begin
                    if (cnt != 4'd0) cnt <= cnt - 4'd1;
                    else state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        sck |-> cs_active) else $error("clock without chip select");             // R3
    AST_CS_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_active) |-> $past(start)) else $error("select without start");  // R2
    AST_DONE_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cs_active && !sck)) else $error("done while lines active");    // R7

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BUF_DEPTH = 16,
    parameter int CNT_W     = 14,
    parameter int NUM_CS    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              op_done_irq
);

    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam int CS_W  = $clog2(NUM_CS);

    cs_timing_t       timing;
    op_ctrl_t         op;
    logic [7:0]       opcode, eng_rdata, eng_wdata;
    logic [CNT_W-1:0] count;
    logic [CS_W-1:0]  cs_sel;
    logic             start, done, eng_we, cs_active;
    logic [IDX_W-1:0] eng_ridx, eng_widx;

    flash_seq_regs #(
        .ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W),
        .CNT_W(CNT_W), .CS_W(CS_W)
    ) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
        .eng_ridx(eng_ridx), .eng_rdata(eng_rdata), .timing(timing),
        .opcode(opcode), .count(count), .cs_sel(cs_sel), .op(op),
        .start(start), .irq(op_done_irq)
    );

    flash_seq_engine #(.IDX_W(IDX_W), .CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst(rst), .start(start), .timing(timing),
        .opcode(opcode), .count(count), .op(op), .miso(spi_miso),
        .buf_rdata(eng_rdata), .buf_ridx(eng_ridx), .buf_we(eng_we),
        .buf_widx(eng_widx), .buf_wdata(eng_wdata), .done(done),
        .cs_active(cs_active), .sck(spi_sck), .mosi(spi_mosi)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign spi_cs_n[g] = !(cs_active && (cs_sel == CS_W'(g)));
    end

    AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n)) else $error("two chip selects low");                // R8

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  spi_cs_n;
    logic        spi_sck, spi_mosi, op_done_irq;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string wave_tag = "R1";

    logic [3:0] exp_q[$];
    logic [7:0] fl_q[$];
    int         fl_off = 0;
    int         rises = 0;

    always #5 clk = !clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .op_done_irq(op_done_irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
            summary();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the serial lines against the reference queue
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            logic [3:0] e;
            int j;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b1100;
            chk(wave_tag, {28'd0, spi_cs_n, spi_sck, spi_mosi}, {28'd0, e});
            if (spi_cs_n == 2'b11) rises = 0;
            else if (spi_sck) rises++;
            j = rises - fl_off;
            if (j >= 0 && j < 8 * fl_q.size()) spi_miso = fl_q[j / 8][7 - (j % 8)];
            else spi_miso = 1'b0;
        end
    end

    task automatic push_n(int n, logic [1:0] cs, logic s, logic m);
        for (int i = 0; i < n; i++) exp_q.push_back({cs, s, m});
    endtask

    // reference waveform from the requirements: R2 R3 R7
    task automatic build(int setup, int hold, int desel, int csi, logic [7:0] bytes[$]);
        logic [1:0] lo;
        lo = (csi == 0) ? 2'b10 : 2'b01;
        push_n(2, 2'b11, 1'b0, 1'b0);
        push_n(setup + 1, lo, 1'b0, 1'b0);
        foreach (bytes[k]) begin
            for (int b = 7; b >= 0; b--) begin
                push_n(1, lo, 1'b0, bytes[k][b]);
                push_n(1, lo, 1'b1, bytes[k][b]);
            end
        end
        push_n(hold + 1, lo, 1'b0, 1'b0);
        push_n(desel + 1, 2'b11, 1'b0, 1'b0);
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic go(logic [31:0] opw, int setup, int hold, int desel, int csi,
                      logic [7:0] bytes[$]);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'd4; reg_wdata = opw;
        build(setup, hold, desel, csi, bytes);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    task automatic finish_op();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        logic [7:0] seq[$];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk("R1 cs_n", {30'd0, spi_cs_n}, 32'd3);
        chk("R1 sck/mosi", {30'd0, spi_sck, spi_mosi}, 32'd0);
        chk("R1 irq", {31'd0, op_done_irq}, 32'd0);
        rd(7'd0, v); chk("R1 timing", v, 32'd0);
        rd(7'd1, v); chk("R1 opcode", v, 32'd0);
        rd(7'd2, v); chk("R1 count", v, 32'd0);
        rd(7'd4, v); chk("R1 opctrl", v, 32'd0);

        // A: read 3 bytes after opcode on cs0; setup 2, hold 1, deselect 3 (R2 R3 R4 R6)
        wave_tag = "R2/R3/R4 read waveform";
        wr(7'd0, 32'h123);
        wr(7'd1, 32'h9F);
        wr(7'd2, 32'd3);
        wr(7'd3, 32'd0);
        fl_q = '{8'hC2, 8'h20, 8'h18}; fl_off = 8;
        seq = '{8'h9F, 8'h00, 8'h00, 8'h00};
        go(32'h85, 2, 1, 3, 0, seq);
        rd(7'd4, v); chk("R9 start reads 1 while busy", v & 32'h1, 32'h1);
        finish_op();
        chk("R9 done flag set", {31'd0, op_done_irq}, 32'd1);
        rd(7'd4, v); chk("R9 start cleared", v, 32'h84);
        rd(7'h40, v); chk("R6 buf0", v, 32'hC2);
        rd(7'h41, v); chk("R6 buf1", v, 32'h20);
        rd(7'h42, v); chk("R6 buf2", v, 32'h18);
        wr(7'd6, 32'h1);
        chk("R9 flag cleared", {31'd0, op_done_irq}, 32'd0);

        // B: program 4 bytes on cs1, zero timing; write beats read; busy writes ignored (R5 R8 R10)
        wave_tag = "R5/R8/R10 write waveform";
        wr(7'h40, 32'hA5); wr(7'h41, 32'h3C); wr(7'h42, 32'h01); wr(7'h43, 32'hFE);
        wr(7'd0, 32'h000);
        wr(7'd1, 32'h02);
        wr(7'd2, 32'hC004);
        rd(7'd2, v); chk("R5 count 14 bits", v, 32'd4);
        wr(7'd3, 32'h800);
        fl_q = '{8'hFF}; fl_off = 0;
        seq = '{8'h02, 8'hA5, 8'h3C, 8'h01, 8'hFE};
        go(32'hA5, 0, 0, 0, 1, seq);
        repeat (5) @(negedge clk);
        wr(7'd1, 32'h55);
        wr(7'd0, 32'hFFF);
        wr(7'd4, 32'h81);
        wr(7'h40, 32'h00);
        finish_op();
        repeat (4) @(negedge clk);
        rd(7'd1, v); chk("R10 opcode kept", v, 32'h02);
        rd(7'd0, v); chk("R10 timing kept", v, 32'h000);
        rd(7'd4, v); chk("R10 op bits kept", v, 32'hA4);
        rd(7'h40, v); chk("R5 buf0 untouched", v, 32'hA5);
        rd(7'h43, v); chk("R5 buf3 untouched", v, 32'hFE);
        wr(7'd6, 32'h1);

        // C: opcode only, maximum timing on cs0 (R7)
        wave_tag = "R7 opcode-only waveform";
        wr(7'd0, 32'hFFF);
        wr(7'd1, 32'h06);
        wr(7'd2, 32'd0);
        wr(7'd3, 32'd0);
        seq = '{8'h06};
        go(32'hA1, 15, 15, 15, 0, seq);
        finish_op();
        chk("R7 done after opcode only", {31'd0, op_done_irq}, 32'd1);
        wr(7'd6, 32'h1);

        // D: status read with no command phase (R6 R4)
        wave_tag = "R4/R6 status waveform";
        wr(7'd0, 32'h111);
        wr(7'd2, 32'd2);
        fl_q = '{8'h5A, 8'h81}; fl_off = 0;
        seq = '{8'h00, 8'h00};
        go(32'h03, 1, 1, 1, 0, seq);
        finish_op();
        rd(7'h40, v); chk("R6 status buf0", v, 32'h5A);
        rd(7'h41, v); chk("R6 status buf1", v, 32'h81);
        rd(7'd5, v); chk("R9 status reg bit0", v, 32'h1);
        wr(7'd6, 32'h1);
        rd(7'd5, v); chk("R9 status cleared", v, 32'h0);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule